// File: doc/BRIEF.md
# Read-to-Clear Interrupt Aggregator

This block gathers one-cycle event pulses from up to sixteen source positions into two sticky 8-bit flag banks. It drives one active-low request line to a host processor. Fourteen positions are mapped to events, and one of those is reserved and never sets. Each bank has a matching enable bank that decides which pending flags may pull the request low. A flag is captured whether or not its source is enabled. The request line is a level and stays low until the host has cleared every flag whose enable bit is set.

The host uses a small synchronous register port with an address, a read strobe, a write strobe, write data and registered read data. Each flag bank can be read in two ways. A destructive read returns the flags and clears them. A peek returns the same flags and leaves them in place. This allows either interrupt-driven servicing or polling without losing information. The event logic in the peripherals and the bridge to the host bus are outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: `src_evt_i[7:0]` sets flag bank 0 bit 7..0 at the same index: bit 7 end of packet, 6 receive buffer empty, 5 self-initialisation done, 4 oscillator ready, 3 flash operation done, 2 packet transmitted, 1 receive buffer full or packet limit reached, 0 packet received. A flag is set on the clock edge that samples its pulse.
- R2: `src_evt_i[8+k]` sets flag bank 1 bit k for k = 0 (auto-negotiation complete), 2 (auto-negotiation failed), 3 (jabber), 4 (link change) and 5 (wake event). Bank 1 bits 1, 6 and 7 never set and always read 0, so `src_evt_i[9]`, `src_evt_i[14]` and `src_evt_i[15]` have no effect.
- R3: `irq_n_o` is low in the cycle after any edge that leaves a flag set together with its enable bit. It is high otherwise. It is a level and is registered.
- R4: `irq_n_o` stays low until every enabled pending flag in both banks has been cleared. Clearing only one bank while the other still holds an enabled flag keeps it low.
- R5: A read with `rd_en_i` high at address 0 (bank 0) or address 1 (bank 1) returns that bank's flags as they were before the edge. On the same edge it clears that bank's flags.
- R6: A flag clears only through a destructive read of its own bank. Peeks, enable writes, writes to any address and reads of other addresses leave it set.
- R7: Enable registers sit at address 2 (bank 0) and address 3 (bank 1) and use the same bit layout as the flag banks. A cleared enable bit keeps its flag from driving `irq_n_o`, but the flag is still captured. Setting the enable bit while the flag is pending pulls `irq_n_o` low on that same write edge.
- R8: A read at address 4 (bank 0) or address 5 (bank 1) returns the flags and changes no flag.
- R9: If an event pulse arrives in the same cycle as a destructive read of its bank, the read returns the old value and the flag is set afterwards.
- R10: After reset all flags are 0, enable bank 0 is 0xFF, enable bank 1 is 0x3D, `irq_n_o` is 1 and `rd_data_o` is 0.
- R11: Writes to addresses 0, 1, 4, 5, 6 and 7 have no effect. A write to enable bank 1 stores only bits 5..2 and 0. Reads of addresses 6 and 7 return 0.
- R12: `rd_data_o` is updated on the edge that samples `rd_en_i`, with enable reads returning the enable bank. It holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt_i | input | 16 | One-cycle event pulses; bits 7..0 go to bank 0, bits 15..8 go to bank 1 |
| addr_i | input | 3 | Register address |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Interrupt request, active low level |

## Verification
Two things can happen on the same edge: the clear caused by a destructive read, and the capture of a new event pulse into the bank being read. A second pair is an enable write that arrives while a flag is already pending. The bench provokes the first by driving a pulse in the very cycle that the read strobe hits a bank with a flag already set. It judges the result from the returned value, which must be the old flags, and from a following peek, which must show only the new pulse. The second pair is provoked by enabling bits one at a time while every flag is pending. Each write must pull the request low at once. Around these cases the bench sweeps every one of the sixteen source positions through capture, peek, destructive read and a second peek. A reference model computes the expected results.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 3;

    // Positions that exist in each bank; everything else is tied off.
    localparam logic [DATA_W-1:0] BANK0_VALID = 8'hFF;
    localparam logic [DATA_W-1:0] BANK1_VALID = 8'h3D;

    function automatic logic [DATA_W-1:0] bank_valid(input int bank);
        return (bank == 0) ? BANK0_VALID : BANK1_VALID;
    endfunction

    // Address groups: destructive status, enable, non-destructive peek.
    localparam int STAT_BASE = 0;
    localparam int EN_BASE   = NUM_BANKS;
    localparam int PEEK_BASE = 2 * NUM_BANKS;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] VALID  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] flag_q_o,
    output logic [DATA_W-1:0] flag_d_o
);

    typedef struct packed {
        logic [DATA_W-1:0] flags;
    } bank_state_t;

    bank_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.flags = '0;
        end
        // New pulses win over the clear so nothing arriving mid-read is lost.
        s_d.flags = (s_d.flags | evt_i) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_q_o = s_q.flags;
    assign flag_d_o = s_d.flags;

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((flag_q_o & $past(flag_q_o)) == $past(flag_q_o)));

    // R9
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & VALID)) |=> ((flag_q_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));

    // R5
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|evt_i)) |=> (flag_q_o == '0));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] VALID  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] en_q_o,
    output logic [DATA_W-1:0] en_d_o
);

    typedef struct packed {
        logic [DATA_W-1:0] en;
    } en_state_t;

    en_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.en = wdata_i & VALID;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en <= VALID;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_q_o = s_q.en;
    assign en_d_o = s_d.en;

    // R7
    en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q_o));

endmodule

// File: rtl/irq_host_port.sv
module irq_host_port #(
    parameter int NUM_BANKS = 2,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              rd_i,
    input  logic                              wr_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  flags_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0]  en_i,
    output logic [NUM_BANKS-1:0]              clr_o,
    output logic [NUM_BANKS-1:0]              en_wr_o,
    output logic [DATA_W-1:0]                 rdata_o
);

    import irq_agg_pkg::STAT_BASE;
    import irq_agg_pkg::EN_BASE;
    import irq_agg_pkg::PEEK_BASE;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_state_t;

    port_state_t       s_d, s_q;
    logic [DATA_W-1:0] rsel;

    always_comb begin
        s_d     = s_q;
        clr_o   = '0;
        en_wr_o = '0;
        rsel    = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == ADDR_W'(STAT_BASE + b)) begin
                rsel     = flags_i[b];
                clr_o[b] = rd_i;
            end
            if (addr_i == ADDR_W'(EN_BASE + b)) begin
                rsel       = en_i[b];
                en_wr_o[b] = wr_i;
            end
            if (addr_i == ADDR_W'(PEEK_BASE + b)) begin
                rsel = flags_i[b];
            end
        end
        // Snapshot taken on the same edge as the clear.
        if (rd_i) begin
            s_d.rdata = rsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata_o = s_q.rdata;

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

    // R5
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(clr_o) <= 1);

endmodule

// File: rtl/irq_request.sv
module irq_request #(
    parameter int NUM_BANKS = 2,
    parameter int DATA_W    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] flag_d_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] en_d_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] flag_q_i,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] en_q_i,
    output logic                             irq_n_o
);

    typedef struct packed {
        logic irq_n;
    } req_state_t;

    req_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.irq_n = ~(|(flag_d_i & en_d_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.irq_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_n_o = s_q.irq_n;

    // R3
    req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o == !(|(flag_q_i & en_q_i)));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && (|(flag_d_i & en_d_i))) |=> !irq_n_o);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    localparam int EVT_W = NUM_BANKS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  src_evt_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_n_o
);

    logic [NUM_BANKS-1:0][DATA_W-1:0] flag_q, flag_d, en_q, en_d;
    logic [NUM_BANKS-1:0]             clr, en_wr;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irq_flag_bank #(
            .DATA_W (DATA_W),
            .VALID  (bank_valid(b))
        ) flag_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (src_evt_i[b*DATA_W +: DATA_W]),
            .clr_i    (clr[b]),
            .flag_q_o (flag_q[b]),
            .flag_d_o (flag_d[b])
        );

        irq_enable_reg #(
            .DATA_W (DATA_W),
            .VALID  (bank_valid(b))
        ) en_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (en_wr[b]),
            .wdata_i (wr_data_i),
            .en_q_o  (en_q[b]),
            .en_d_o  (en_d[b])
        );
    end

    irq_host_port #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) port_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .rd_i    (rd_en_i),
        .wr_i    (wr_en_i),
        .flags_i (flag_q),
        .en_i    (en_q),
        .clr_o   (clr),
        .en_wr_o (en_wr),
        .rdata_o (rd_data_o)
    );

    irq_request #(
        .NUM_BANKS (NUM_BANKS),
        .DATA_W    (DATA_W)
    ) req_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_d_i (flag_d),
        .en_d_i   (en_d),
        .flag_q_i (flag_q),
        .en_q_i   (en_q),
        .irq_n_o  (irq_n_o)
    );

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(STAT_BASE + 1)) |=> (rd_data_o[1] == 1'b0));

endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [15:0] mf = '0;
    logic [15:0] men = 16'h3DFF;
    logic [7:0]  m_rdata = '0;
    localparam logic [15:0] MAP = 16'h3DFF;

    always #4 clk = ~clk;

    irq_aggregator dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_evt_i (evt),
        .addr_i    (addr),
        .rd_en_i   (rd),
        .wr_en_i   (wr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_n_o   (irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd4: return mf[7:0];
            3'd1, 3'd5: return mf[15:8];
            3'd2:       return men[7:0];
            3'd3:       return men[15:8];
            default:    return 8'h00;
        endcase
    endfunction

    // One bus cycle plus one idle cycle; checks read data and request level.
    task automatic step(input logic [2:0] a, input logic r, input logic w,
                        input logic [7:0] wd, input logic [15:0] ev, input string tag);
        @(negedge clk);
        addr = a; rd = r; wr = w; wdata = wd; evt = ev;
        if (r) m_rdata = model_read(a);
        if (r && a == 3'd0) mf[7:0]  = '0;
        if (r && a == 3'd1) mf[15:8] = '0;
        if (w && a == 3'd2) men[7:0]  = wd;
        if (w && a == 3'd3) men[15:8] = wd & 8'h3D;
        mf = mf | (ev & MAP);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0; evt = '0;
        check({tag, " rdata"}, rdata, m_rdata);
        check({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, ~(|(mf & men))});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 rdata", rdata, 8'h00);
        check("R10 irq_n", {7'b0, irq_n}, 8'h01);
        step(3'd2, 1, 0, 0, 0, "R10 en0");
        step(3'd3, 1, 0, 0, 0, "R10 en1");
        step(3'd4, 1, 0, 0, 0, "R10 peek0");
        step(3'd5, 1, 0, 0, 0, "R10 peek1");

        // R1 R2 R3 R5 R8: sweep every source position
        for (int i = 0; i < 16; i++) begin
            logic [2:0] bank;
            bank = (i < 8) ? 3'd0 : 3'd1;
            step(3'd0, 0, 0, 0, 16'(1) << i, "R1 R2 R3 capture");
            step(3'd4 + bank, 1, 0, 0, 0, "R8 R2 peek");
            step(3'd4 + bank, 1, 0, 0, 0, "R8 repeat peek");
            step(bank, 1, 0, 0, 0, "R5 destructive");
            step(3'd4 + bank, 1, 0, 0, 0, "R5 after clear");
        end

        // R7: capture while disabled, then enable one bit at a time
        step(3'd2, 0, 1, 8'h00, 0, "R7 dis0");
        step(3'd3, 0, 1, 8'h00, 0, "R7 dis1");
        step(3'd0, 0, 0, 0, 16'hFFFF, "R7 masked capture");
        step(3'd4, 1, 0, 0, 0, "R7 peek0");
        step(3'd5, 1, 0, 0, 0, "R7 peek1");
        for (int j = 0; j < 8; j++) begin
            step(3'd2, 0, 1, 8'(1 << j), 0, "R7 enable0 pending");
            step(3'd2, 0, 1, 8'h00, 0, "R7 disable0");
        end
        for (int j = 0; j < 8; j++) begin
            step(3'd3, 0, 1, 8'(1 << j), 0, "R7 enable1 pending");
            step(3'd3, 1, 1, 8'h00, 0, "R7 R11 disable1");
        end
        step(3'd2, 0, 1, 8'hFF, 0, "R7 restore0");
        step(3'd3, 0, 1, 8'hFF, 0, "R11 restore1");
        step(3'd3, 1, 0, 0, 0, "R11 en1 masked");

        // R6 R11: writes to flag addresses and unmapped reads
        for (int a = 0; a < 8; a++) begin
            if (a != 2 && a != 3) begin
                step(3'(a), 0, 1, 8'h00, 0, "R6 R11 ignored write");
                step(3'd4, 1, 0, 0, 0, "R6 peek0");
                step(3'd5, 1, 0, 0, 0, "R6 peek1");
            end
        end
        step(3'd6, 1, 0, 0, 0, "R11 unmapped6");
        step(3'd7, 1, 0, 0, 0, "R11 unmapped7");

        // R4: clear bank 0 only, request stays; then bank 1
        step(3'd0, 1, 0, 0, 0, "R4 clear bank0");
        step(3'd5, 1, 0, 0, 0, "R4 bank1 still pending");
        step(3'd1, 1, 0, 0, 0, "R4 clear bank1");

        // R9: event during destructive read of its bank
        step(3'd0, 0, 0, 0, 16'h0008, "R9 pre");
        step(3'd0, 1, 0, 0, 16'h0028, "R9 collide0");
        step(3'd4, 1, 0, 0, 0, "R9 survived0");
        step(3'd1, 0, 0, 0, 16'h0400, "R9 pre1");
        step(3'd1, 1, 0, 0, 16'h2100, "R9 collide1");
        step(3'd5, 1, 0, 0, 0, "R9 survived1");

        // R12: read data holds without a read
        step(3'd0, 0, 0, 0, 0, "R12 hold a");
        step(3'd2, 0, 0, 0, 0, "R12 hold b");
        step(3'd0, 1, 0, 0, 0, "R12 final clear0");
        step(3'd1, 1, 0, 0, 0, "R12 final clear1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule